// File: doc/BRIEF.md
# Burst Address Generator

This block turns one memory-mapped address request into the list of beat addresses that the request covers. A request carries a start address, a beat count minus one, a transfer size given as log2 of the byte count, and a burst kind. Once the request is accepted, the block presents one beat at a time. Each beat carries its byte address, the byte lanes it enables on a data bus of `DATA_BYTES` bytes, and a flag that marks the final beat. It moves to the next beat only when the consumer takes the current one.

Three burst kinds are handled. A constant-address kind repeats the first address on every beat. An incrementing kind steps by the transfer size; when it starts unaligned, only its first beat has a partial lane set. A wrapping kind cycles inside an aligned window. Before any beat is produced, the block checks the request against the length, wrap, alignment, size and 4 KB page rules. A request that breaks any of them gets a one-cycle error pulse instead of beats.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, req_ready is 1, and beat_valid, beat_last, req_err and beat_strb are all 0. A reset in the middle of a burst drops the burst.
- R2: Burst code 2'b00 (constant address): every beat carries the start address and the same lane set.
- R3: Burst code 2'b01 (incrementing): beat 0 carries the start address. Beat i>0 carries the start address aligned down to 2^size, plus i×2^size.
- R4: Burst code 2'b10 (wrapping): beat i carries base + ((start − base + i×2^size) mod W), where W = (len+1)×2^size and base is the start address aligned down to W.
- R5: A burst has len+1 beats. beat_last is 1 only on the final beat. beat_valid falls in the cycle after the final beat is taken.
- R6: A request is taken only on a rising clock edge where req_valid and req_ready are both 1, and req_ready is 0 while a burst is in progress. A beat advances only when beat_valid and beat_ready are both 1. Otherwise the beat's address and lanes hold.
- R7: beat_strb bit j is 1 when j lies between a mod DATA_BYTES and the last byte of the 2^size-aligned chunk that holds a, where a is the beat address.
- R8: An incrementing burst may have len 0 to 255. A constant or wrapping burst with len above 15 is illegal. A wrapping burst is legal only with len 1, 3, 7 or 15.
- R9: An incrementing burst is illegal when its last byte, counted from the size-aligned start, falls in a different 4 KB page from its start. Ending exactly on the page edge is legal.
- R10: Burst code 2'b11, a size above log2(DATA_BYTES), and a wrapping burst whose start is not aligned to 2^size are illegal.
- R11: An illegal request is taken like any other. In the next cycle req_err is 1 for exactly one cycle, no beat appears, and req_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Generator idle, so a request can be taken |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | 8 | Beat count minus one |
| req_size | input | 3 | log2 of the bytes per beat |
| req_burst | input | 2 | Burst kind: 00 constant, 01 incrementing, 10 wrapping |
| req_err | output | 1 | One-cycle pulse for an illegal request |
| beat_valid | output | 1 | A beat is presented |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| beat_strb | output | DATA_BYTES | Enabled byte lanes of the current beat |
| beat_last | output | 1 | Current beat is the final one |

## Verification
The last-beat flag and the wrap back to the window base can fall on the same beat. The bench provokes this with a four-beat wrapping burst that starts one transfer above the base of its window, so the final beat is the wrapped one. It judges that beat on its address (the base), its lanes and its last flag all together. A second coincidence is the last-beat handshake of one burst while the next request is already held valid. There the bench requires exactly one idle cycle with req_ready high before the new burst's first beat.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic [1:0] {
    BT_FIXED = 2'b00,
    BT_INCR  = 2'b01,
    BT_WRAP  = 2'b10,
    BT_RSVD  = 2'b11
  } burst_e;

  localparam int PAGE_BITS = 12;
endpackage

// File: rtl/bag_legal.sv
module bag_legal #(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        len,
  input  logic [2:0]        size,
  input  logic [1:0]        burst,
  output logic              illegal
);
  import bag_pkg::*;

  localparam int SPAN_W = 18;

  logic [SPAN_W-1:0] unit, span, start_off, end_off;
  logic size_bad, len_bad, wrap_bad, page_cross, misalign, rsvd;

  always_comb begin
    unit       = SPAN_W'(1) << size;
    span       = (SPAN_W'(len) + SPAN_W'(1)) << size;
    start_off  = SPAN_W'(addr[PAGE_BITS-1:0]) & ~(unit - SPAN_W'(1));
    end_off    = start_off + span;
    page_cross = end_off > (SPAN_W'(1) << PAGE_BITS);
    misalign   = (SPAN_W'(addr[PAGE_BITS-1:0]) & (unit - SPAN_W'(1))) != '0;
    size_bad   = {1'b0, size} > 4'(LANE_W);
    len_bad    = (burst != BT_INCR) && (len > 8'd15);
    wrap_bad   = (burst == BT_WRAP) &&
                 (!((len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15)) || misalign);
    rsvd       = (burst == BT_RSVD);
    illegal    = size_bad || len_bad || wrap_bad || rsvd ||
                 ((burst == BT_INCR) && page_cross);
  end
endmodule

// File: rtl/bag_step.sv
module bag_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        len,
  input  logic [2:0]        size,
  input  logic [1:0]        burst,
  output logic [ADDR_W-1:0] nxt
);
  import bag_pkg::*;

  logic [ADDR_W-1:0] unit, win_mask, bumped;

  always_comb begin
    unit     = ADDR_W'(1) << size;
    win_mask = ((ADDR_W'(len) + ADDR_W'(1)) << size) - ADDR_W'(1);
    bumped   = (addr & ~(unit - ADDR_W'(1))) + unit;
    case (burst)
      BT_FIXED: nxt = addr;
      BT_INCR:  nxt = bumped;
      BT_WRAP:  nxt = (addr & ~win_mask) | (bumped & win_mask);
      default:  nxt = addr;
    endcase
  end
endmodule

// File: rtl/bag_strb.sv
module bag_strb #(
  parameter int DATA_BYTES = 8,
  parameter int LANE_W     = 3
) (
  input  logic [LANE_W-1:0]     lane,
  input  logic [2:0]            size,
  output logic [DATA_BYTES-1:0] strb
);
  localparam int LW1 = LANE_W + 1;

  logic [LW1-1:0] unit, lo, hi_x;

  always_comb begin
    unit = LW1'(1) << size;
    lo   = LW1'(lane);
    hi_x = (lo & ~(unit - LW1'(1))) + unit;
  end

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
    assign strb[g] = (LW1'(g) >= lo) && (LW1'(g) < hi_x);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [7:0]            req_len,
  input  logic [2:0]            req_size,
  input  logic [1:0]            req_burst,
  output logic                  req_err,
  output logic                  beat_valid,
  input  logic                  beat_ready,
  output logic [ADDR_W-1:0]     beat_addr,
  output logic [DATA_BYTES-1:0] beat_strb,
  output logic                  beat_last
);
  import bag_pkg::*;

  localparam int LANE_W = $clog2(DATA_BYTES);

  logic                  busy_q, err_q, last_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [DATA_BYTES-1:0] strb_q;
  logic [7:0]            len_q, cnt_q;
  logic [2:0]            size_q;
  logic [1:0]            burst_q;

  logic                  illegal;
  logic [ADDR_W-1:0]     nxt_addr;
  logic [DATA_BYTES-1:0] strb_first, strb_nxt;
  logic                  take_req, take_beat;

  bag_legal #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_legal (
    .addr(req_addr), .len(req_len), .size(req_size), .burst(req_burst), .illegal(illegal)
  );

  bag_step #(.ADDR_W(ADDR_W)) u_step (
    .addr(addr_q), .len(len_q), .size(size_q), .burst(burst_q), .nxt(nxt_addr)
  );

  bag_strb #(.DATA_BYTES(DATA_BYTES), .LANE_W(LANE_W)) u_strb_first (
    .lane(req_addr[LANE_W-1:0]), .size(req_size), .strb(strb_first)
  );

  bag_strb #(.DATA_BYTES(DATA_BYTES), .LANE_W(LANE_W)) u_strb_next (
    .lane(nxt_addr[LANE_W-1:0]), .size(size_q), .strb(strb_nxt)
  );

  assign take_req  = !busy_q && req_valid;
  assign take_beat = busy_q && beat_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      last_q  <= 1'b0;
      addr_q  <= '0;
      strb_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      size_q  <= '0;
      burst_q <= '0;
    end else begin
      err_q <= 1'b0;
      if (take_req) begin
        if (illegal) begin
          err_q <= 1'b1;
        end else begin
          busy_q  <= 1'b1;
          addr_q  <= req_addr;
          strb_q  <= strb_first;
          len_q   <= req_len;
          size_q  <= req_size;
          burst_q <= req_burst;
          cnt_q   <= '0;
          last_q  <= (req_len == 8'd0);
        end
      end else if (take_beat) begin
        if (last_q) begin
          busy_q <= 1'b0;
          last_q <= 1'b0;
          strb_q <= '0;
        end else begin
          addr_q <= nxt_addr;
          strb_q <= strb_nxt;
          cnt_q  <= cnt_q + 8'd1;
          last_q <= ((cnt_q + 8'd1) == len_q);
        end
      end
    end
  end

  assign req_ready  = !busy_q;
  assign req_err    = err_q;
  assign beat_valid = busy_q;
  assign beat_addr  = addr_q;
  assign beat_strb  = strb_q;
  assign beat_last  = last_q;

  logic [ADDR_W-1:0] win_mask_q;
  assign win_mask_q = ((ADDR_W'(len_q) + ADDR_W'(1)) << size_q) - ADDR_W'(1);

  a_r2_fixed_same: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && !beat_last && burst_q == BT_FIXED)
      |=> (beat_addr == $past(beat_addr)));

  a_r3_incr_step: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && !beat_last && burst_q == BT_INCR)
      |=> (beat_addr == ((($past(beat_addr) >> $past(size_q)) + ADDR_W'(1)) << $past(size_q))));

  a_r4_wrap_window: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && !beat_last && burst_q == BT_WRAP)
      |=> (((beat_addr ^ $past(beat_addr)) & ~win_mask_q) == '0));

  a_r5_last_ends: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && beat_last) |=> !beat_valid);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_ready)
      |=> (beat_valid && $stable(beat_addr) && $stable(beat_strb) && $stable(beat_last)));

  a_r7_lanes_set: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> (beat_strb != '0));

  a_r11_err_idle: assert property (@(posedge clk) disable iff (rst)
    req_err |-> (!beat_valid && req_ready));
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int AW = 32;
  localparam int DB = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_ready, req_err;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_len;
  logic [2:0]    req_size;
  logic [1:0]    req_burst;
  logic          beat_valid, beat_ready, beat_last;
  logic [AW-1:0] beat_addr;
  logic [DB-1:0] beat_strb;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .DATA_BYTES(DB)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_size(req_size), .req_burst(req_burst),
    .req_err(req_err), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_addr(beat_addr), .beat_strb(beat_strb), .beat_last(beat_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] st, input logic [7:0] len,
                                             input logic [2:0] sz, input logic [1:0] bt, input int i);
    logic [AW-1:0] unit, win, base;
    unit = AW'(1) << sz;
    case (bt)
      2'b01: exp_addr = (i == 0) ? st : (((st >> sz) + AW'(i)) << sz);
      2'b10: begin
        win      = (AW'(len) + 1) * unit;
        base     = st - (st % win);
        exp_addr = base + (((st - base) + AW'(i) * unit) % win);
      end
      default: exp_addr = st;
    endcase
  endfunction

  function automatic logic [DB-1:0] exp_strb(input logic [AW-1:0] a, input logic [2:0] sz);
    int lo, chunk, unit;
    unit  = 1 << sz;
    lo    = int'(a % DB);
    chunk = lo - (lo % unit);
    for (int j = 0; j < DB; j++) exp_strb[j] = (j >= lo) && (j < chunk + unit);
  endfunction

  task automatic put_req(input logic [AW-1:0] a, input logic [7:0] len,
                         input logic [2:0] sz, input logic [1:0] bt);
    req_addr  = a;
    req_len   = len;
    req_size  = sz;
    req_burst = bt;
    req_valid = 1'b1;
  endtask

  task automatic run_burst(input string tag, input logic [AW-1:0] a, input logic [7:0] len,
                           input logic [2:0] sz, input logic [1:0] bt, input bit stall);
    logic [AW-1:0] ea;
    @(negedge clk);
    chk(req_ready, "R6", {tag, " ready before request"}, 64'(req_ready), 1);
    put_req(a, len, sz, bt);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i <= int'(len); i++) begin
      ea = exp_addr(a, len, sz, bt, i);
      if (stall && (i % 2 == 1)) begin
        beat_ready = 1'b0;
        @(negedge clk);
        chk(beat_valid && beat_addr == ea, "R6", {tag, " stalled beat held"}, 64'(beat_addr), 64'(ea));
      end
      chk(beat_valid, tag, "beat_valid", 64'(beat_valid), 1);
      chk(beat_addr == ea, tag, $sformatf("addr beat %0d", i), 64'(beat_addr), 64'(ea));
      chk(beat_strb == exp_strb(ea, sz), "R7", $sformatf("%s strobe beat %0d", tag, i),
          64'(beat_strb), 64'(exp_strb(ea, sz)));
      chk(beat_last == (i == int'(len)), "R5", $sformatf("%s last beat %0d", tag, i),
          64'(beat_last), 64'(i == int'(len)));
      chk(!req_ready, "R6", {tag, " not ready while busy"}, 64'(req_ready), 0);
      beat_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      beat_ready = 1'b0;
    end
    chk(!beat_valid, "R5", {tag, " valid drops after last"}, 64'(beat_valid), 0);
    chk(req_ready, "R6", {tag, " ready after last"}, 64'(req_ready), 1);
  endtask

  task automatic run_illegal(input string tag, input logic [AW-1:0] a, input logic [7:0] len,
                             input logic [2:0] sz, input logic [1:0] bt);
    @(negedge clk);
    put_req(a, len, sz, bt);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_err, tag, "error pulse", 64'(req_err), 1);
    chk(!beat_valid, "R11", {tag, " no beat"}, 64'(beat_valid), 0);
    chk(req_ready, "R11", {tag, " ready stays"}, 64'(req_ready), 1);
    @(negedge clk);
    chk(!req_err, "R11", {tag, " pulse one cycle"}, 64'(req_err), 0);
    chk(!beat_valid, "R11", {tag, " still no beat"}, 64'(beat_valid), 0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !beat_valid && !beat_last && !req_err && beat_strb == '0, "R1",
        "idle outputs in reset", {req_ready, beat_valid, beat_last, req_err, beat_strb}, {5'b10000, 8'h00});
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !beat_valid, "R1", "idle after reset", {req_ready, beat_valid}, 2'b10);
  endtask

  task automatic t_fixed;
    run_burst("R2", 32'h105, 8'd2, 3'd0, 2'b00, 1'b0);
    run_burst("R2", 32'h010, 8'd15, 3'd1, 2'b00, 1'b1);
  endtask

  task automatic t_incr;
    run_burst("R3", 32'h001, 8'd3, 3'd2, 2'b01, 1'b1);
    run_burst("R3", 32'h0F3, 8'd2, 3'd3, 2'b01, 1'b0);
    run_burst("R8", 32'h000, 8'd255, 3'd0, 2'b01, 1'b0);
  endtask

  task automatic t_wrap;
    run_burst("R4", 32'h034, 8'd3, 3'd2, 2'b10, 1'b0);
    run_burst("R4", 32'h058, 8'd7, 3'd3, 2'b10, 1'b1);
    run_burst("R4", 32'h002, 8'd1, 3'd1, 2'b10, 1'b0);
  endtask

  task automatic t_page;
    run_burst("R9", 32'hFF8, 8'd0, 3'd3, 2'b01, 1'b0);
    run_burst("R9", 32'hFFD, 8'd0, 3'd2, 2'b01, 1'b0);
    run_burst("R9", 32'h800, 8'd255, 3'd3, 2'b01, 1'b0);
    run_illegal("R9", 32'hFF8, 8'd1, 3'd3, 2'b01);
    run_illegal("R9", 32'h808, 8'd255, 3'd3, 2'b01);
  endtask

  task automatic t_illegal;
    run_illegal("R10", 32'h100, 8'd0, 3'd0, 2'b11);
    run_illegal("R10", 32'h100, 8'd0, 3'd4, 2'b01);
    run_illegal("R10", 32'h002, 8'd3, 3'd2, 2'b10);
    run_illegal("R8", 32'h100, 8'd16, 3'd0, 2'b00);
    run_illegal("R8", 32'h100, 8'd2, 3'd0, 2'b10);
    run_illegal("R8", 32'h100, 8'd31, 3'd0, 2'b10);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    put_req(32'h040, 8'd1, 3'd3, 2'b01);
    @(posedge clk);
    @(negedge clk);
    put_req(32'h200, 8'd0, 3'd0, 2'b00);
    chk(beat_addr == 32'h040, "R6", "first burst beat 0", 64'(beat_addr), 64'h40);
    beat_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(beat_addr == 32'h048 && beat_last, "R6", "held request ignored while busy",
        64'(beat_addr), 64'h48);
    @(posedge clk);
    @(negedge clk);
    beat_ready = 1'b0;
    chk(!beat_valid && req_ready, "R6", "one idle cycle between bursts",
        {beat_valid, req_ready}, 2'b01);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(beat_valid && beat_addr == 32'h200 && beat_strb == 8'h01 && beat_last, "R6",
        "held request taken after burst", 64'(beat_addr), 64'h200);
    beat_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    beat_ready = 1'b0;
    chk(!beat_valid, "R5", "single beat burst ends", 64'(beat_valid), 0);
  endtask

  task automatic t_mid_reset;
    @(negedge clk);
    put_req(32'h080, 8'd7, 3'd2, 2'b01);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!beat_valid && req_ready && !beat_last && beat_strb == '0, "R1", "reset drops burst",
        {beat_valid, req_ready}, 2'b01);
  endtask

  initial begin
    rst        = 1'b1;
    req_valid  = 1'b0;
    req_addr   = '0;
    req_len    = '0;
    req_size   = '0;
    req_burst  = '0;
    beat_ready = 1'b0;
    t_reset();
    t_fixed();
    t_incr();
    t_wrap();
    t_page();
    t_illegal();
    t_back_to_back();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule